// File: doc/BRIEF.md
# External Asynchronous Memory Bus Controller

This block converts internal CPU and cache requests into cycles on an external asynchronous SRAM-style bus. An internal request carries a byte address, an access size (byte, halfword, word), a write flag, write data and a line flag. The external side presents a byte address, a read strobe, a direction line, one write strobe per byte lane, a split data bus and a WAIT input. A static configuration input picks an 8-bit or 16-bit device.

Requests wider than the device are split into beats at ascending addresses. Read data is packed big-endian: the first byte fetched ends up in the most significant position of the returned value. A line request moves a whole 16-byte cache line from its aligned base as one uninterrupted run of beats. Reads always fetch the full device width. Writes strobe only the lanes that hold written bytes.

Each beat lasts one cycle plus a programmable count of internal wait cycles. When the wait-mode input is 0, one more sample cycle follows. During that cycle, and for as long as WAIT stays high, the beat is stretched. When the wait-mode input is 1, WAIT is ignored and no sample cycle is added. After the last beat the block gives a one-cycle done pulse with the read data.

Top module: `sram_bus_ctrl`

## Requirements
- R1: When no access is in progress: `ext_rd_n`=1, `ext_rdwr`=1 (read direction), `ext_we_n`=2'b11, `ext_dq_oe`=0 and `req_ready`=1. This holds out of reset and between accesses.
- R2: A read fetches the full device width whatever its size. A byte read on a 16-bit device is one beat and returns both bytes of the addressed halfword in `rsp_rdata[15:0]`: the even byte in [15:8], the odd byte in [7:0].
- R3: The external address of the first beat of a non-line access equals the request's byte address, including odd addresses.
- R4: Write strobes are active low. `ext_we_n[1]` strobes D15:8, which is the even byte on a 16-bit device. `ext_we_n[0]` strobes D7:0, which is the odd byte on a 16-bit device and every byte on an 8-bit device. Only the strobes of bytes actually written go low, and an 8-bit device never gets `ext_we_n[1]`.
- R5: A request wider than the device runs as consecutive beats at addresses rising by the device width: a word takes 2 beats on 16 bits and 4 on 8 bits. Read data is packed big-endian into the low bytes of `rsp_rdata`. Write data is taken big-endian from the low bytes of `req_wdata`.
- R6: A line request moves 16 bytes starting at the address with bits [3:0] cleared. That is 8 beats at 16 bits or 16 beats at 8 bits. A strobe is active in every cycle from the first beat to the last, with no idle cycle between beats.
- R7: With `cfg_nowait`=0 each beat has one extra WAIT sample cycle, repeated for as long as `ext_wait`=1.
- R8: With `cfg_nowait`=1 `ext_wait` has no effect and no sample cycle is added.
- R9: Each beat first holds its strobes for 1+`cfg_iwait` cycles.
- R10: `rsp_done` is a one-cycle pulse after the last beat. A request raised while busy (`req_ready`=0) is ignored.
- R11: During write beats `ext_rdwr`=0 and `ext_dq_oe`=1. During read beats `ext_rdwr`=1 and `ext_dq_oe`=0, and the read and write strobes are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_wide | input | 1 | 1 = 16-bit device, 0 = 8-bit device (static) |
| cfg_nowait | input | 1 | 1 = ignore WAIT, no sample cycle (static) |
| cfg_iwait | input | 3 | Internal wait cycles per beat (static) |
| req_valid | input | 1 | Request strobe, taken when `req_ready`=1 |
| req_ready | output | 1 | Block idle |
| req_write | input | 1 | 1 = write |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_burst | input | 1 | Move a whole 16-byte line |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | LINE_BYTES*8 | Write data, right-aligned |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | LINE_BYTES*8 | Read data, right-aligned, big-endian |
| ext_addr | output | ADDR_W | External byte address |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_rdwr | output | 1 | Direction, 1 = read |
| ext_we_n | output | 2 | Per-lane write strobes, active low |
| ext_dq_o | output | 16 | Write data to the bus |
| ext_dq_oe | output | 1 | Data bus drive enable |
| ext_dq_i | input | 16 | Read data from the bus |
| ext_wait | input | 1 | External wait, active high |

## Verification
Reads are run at byte, word and line size on both device widths against a byte-addressed memory model. Comparing the returned words with the model separates correct big-endian packing and ascending beat addresses from lane swaps or wrong beat counts, and an odd-address byte read separates the true start address from an aligned one. Byte and halfword writes followed by read-back show that neighbouring bytes are left untouched, which singles out wrong strobe lanes. Timed runs that hold WAIT high under both wait modes, and with a nonzero internal wait count, tell the sample cycle, the stretch and the per-beat count apart by the exact number of active strobe cycles.

// File: rtl/sram_bus_pkg.sv
package sram_bus_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_WSMP = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sram_beat_plan.sv
module sram_beat_plan #(
  parameter int ADDR_W     = 24,
  parameter int LINE_BYTES = 16,
  localparam int LW        = LINE_BYTES * 8,
  localparam int BEAT_W    = $clog2(LINE_BYTES),
  localparam int CNT_W     = BEAT_W + 1
) (
  input  logic              cfg_wide,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_burst,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LW-1:0]     req_wdata,
  output logic [ADDR_W-1:0] base_addr,
  output logic [BEAT_W-1:0] last_beat,
  output logic [1:0]        lane_n,
  output logic              single_byte,
  output logic [LW-1:0]     wdata_aligned
);
  import sram_bus_pkg::*;

  localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(LINE_BYTES - 1);

  logic [CNT_W-1:0] nbytes;
  logic [CNT_W-1:0] beats;

  always_comb begin
    if (req_burst) begin
      nbytes = CNT_W'(LINE_BYTES);
    end else begin
      case (acc_size_e'(req_size))
        SZ_BYTE: nbytes = CNT_W'(1);
        SZ_HALF: nbytes = CNT_W'(2);
        default: nbytes = CNT_W'(4);
      endcase
    end
    // reads always take the full device width
    if (!req_write && cfg_wide && nbytes == CNT_W'(1)) nbytes = CNT_W'(2);

    single_byte = cfg_wide && (nbytes == CNT_W'(1));
    if (!cfg_wide)        beats = nbytes;
    else if (single_byte) beats = CNT_W'(1);
    else                  beats = nbytes >> 1;
    last_beat = BEAT_W'(beats - CNT_W'(1));

    base_addr = req_burst ? (req_addr & ~LINE_MASK) : req_addr;

    if (!cfg_wide)        lane_n = 2'b10;
    else if (single_byte) lane_n = req_addr[0] ? 2'b10 : 2'b01;
    else                  lane_n = 2'b00;

    wdata_aligned = req_wdata << (LW - 8 * int'(nbytes));
  end
endmodule

// File: rtl/sram_beat_seq.sv
module sram_beat_seq #(
  parameter int LINE_BYTES = 16,
  parameter int IWAIT_W    = 3,
  localparam int BEAT_W    = $clog2(LINE_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               cfg_nowait,
  input  logic [IWAIT_W-1:0] cfg_iwait,
  input  logic               ext_wait,
  input  logic [BEAT_W-1:0]  last_beat,
  output logic               active,
  output logic               beat_end,
  output logic               final_end,
  output logic [BEAT_W-1:0]  beat_idx
);
  import sram_bus_pkg::*;

  seq_state_e         state_q, state_d;
  logic [IWAIT_W-1:0] icnt_q, icnt_d;
  logic [BEAT_W-1:0]  beat_q, beat_d;

  always_comb begin
    state_d  = state_q;
    icnt_d   = icnt_q;
    beat_d   = beat_q;
    beat_end = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_ACC;
        icnt_d  = cfg_iwait;
        beat_d  = '0;
      end
      ST_ACC: begin
        if (icnt_q != '0)    icnt_d = icnt_q - IWAIT_W'(1);
        else if (cfg_nowait) beat_end = 1'b1;
        else                 state_d = ST_WSMP;
      end
      ST_WSMP: if (!ext_wait) beat_end = 1'b1;
      default: state_d = ST_IDLE;
    endcase
    if (beat_end) begin
      if (beat_q == last_beat) begin
        state_d = ST_IDLE;
      end else begin
        state_d = ST_ACC;
        beat_d  = beat_q + BEAT_W'(1);
        icnt_d  = cfg_iwait;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      icnt_q  <= '0;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      icnt_q  <= icnt_d;
      beat_q  <= beat_d;
    end
  end

  assign active    = (state_q != ST_IDLE);
  assign final_end = beat_end && (beat_q == last_beat);
  assign beat_idx  = beat_q;

  assert_wait_stretch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WSMP && ext_wait) |=> (state_q == ST_WSMP));
  assert_no_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WSMP) |-> !cfg_nowait);
  assert_iwait_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACC && icnt_q != '0) |=> (state_q == ST_ACC));
  assert_line_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !final_end) |=> active);
endmodule

// File: rtl/sram_lane_path.sv
module sram_lane_path #(
  parameter int LINE_BYTES = 16,
  localparam int LW        = LINE_BYTES * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          shift,
  input  logic          wide,
  input  logic [LW-1:0] wdata_in,
  input  logic [15:0]   dq_in,
  output logic [15:0]   wtop,
  output logic [LW-1:0] rdata
);
  logic [LW-1:0] wreg_q, wreg_d;
  logic [LW-1:0] rreg_q, rreg_d;
  logic          en;

  always_comb begin
    en     = load || shift;
    wreg_d = wreg_q;
    rreg_d = rreg_q;
    if (load) begin
      wreg_d = wdata_in;
      rreg_d = '0;
    end else if (shift) begin
      if (wide) begin
        wreg_d = wreg_q << 16;
        rreg_d = {rreg_q[LW-17:0], dq_in};
      end else begin
        wreg_d = wreg_q << 8;
        rreg_d = {rreg_q[LW-9:0], dq_in[7:0]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wreg_q <= '0;
      rreg_q <= '0;
    end else if (en) begin
      wreg_q <= wreg_d;
      rreg_q <= rreg_d;
    end
  end

  assign wtop  = wreg_q[LW-1 -: 16];
  assign rdata = rreg_q;
endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl #(
  parameter int ADDR_W     = 24,
  parameter int LINE_BYTES = 16,
  parameter int IWAIT_W    = 3,
  localparam int LW        = LINE_BYTES * 8,
  localparam int BEAT_W    = $clog2(LINE_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wide,
  input  logic               cfg_nowait,
  input  logic [IWAIT_W-1:0] cfg_iwait,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [1:0]         req_size,
  input  logic               req_burst,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [LW-1:0]      req_wdata,
  output logic               rsp_done,
  output logic [LW-1:0]      rsp_rdata,
  output logic [ADDR_W-1:0]  ext_addr,
  output logic               ext_rd_n,
  output logic               ext_rdwr,
  output logic [1:0]         ext_we_n,
  output logic [15:0]        ext_dq_o,
  output logic               ext_dq_oe,
  input  logic [15:0]        ext_dq_i,
  input  logic               ext_wait
);
  logic [ADDR_W-1:0] p_base;
  logic [BEAT_W-1:0] p_last;
  logic [1:0]        p_lane_n;
  logic              p_single;
  logic [LW-1:0]     p_wdata;

  logic              active, beat_end, final_end, start;
  logic [BEAT_W-1:0] beat_idx;
  logic [15:0]       wtop;

  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] last_q;
  logic [1:0]        lane_q;
  logic              single_q, write_q, done_q;

  assign start = req_valid && !active;

  sram_beat_plan #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_plan (
    .cfg_wide(cfg_wide), .req_write(req_write), .req_size(req_size),
    .req_burst(req_burst), .req_addr(req_addr), .req_wdata(req_wdata),
    .base_addr(p_base), .last_beat(p_last), .lane_n(p_lane_n),
    .single_byte(p_single), .wdata_aligned(p_wdata)
  );

  sram_beat_seq #(.LINE_BYTES(LINE_BYTES), .IWAIT_W(IWAIT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_nowait(cfg_nowait),
    .cfg_iwait(cfg_iwait), .ext_wait(ext_wait), .last_beat(last_q),
    .active(active), .beat_end(beat_end), .final_end(final_end),
    .beat_idx(beat_idx)
  );

  sram_lane_path #(.LINE_BYTES(LINE_BYTES)) u_lanes (
    .clk(clk), .rst_n(rst_n), .load(start), .shift(beat_end),
    .wide(cfg_wide), .wdata_in(p_wdata), .dq_in(ext_dq_i),
    .wtop(wtop), .rdata(rsp_rdata)
  );

  // request plan is captured once, with a clock enable on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      last_q   <= '0;
      lane_q   <= 2'b11;
      single_q <= 1'b0;
      write_q  <= 1'b0;
    end else if (start) begin
      base_q   <= p_base;
      last_q   <= p_last;
      lane_q   <= p_lane_n;
      single_q <= p_single;
      write_q  <= req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= final_end;
  end

  assign req_ready = !active;
  assign rsp_done  = done_q;
  assign ext_addr  = base_q + (ADDR_W'(beat_idx) << cfg_wide);
  assign ext_rd_n  = !(active && !write_q);
  assign ext_rdwr  = !(active && write_q);
  assign ext_we_n  = (active && write_q) ? lane_q : 2'b11;
  assign ext_dq_oe = active && write_q;
  assign ext_dq_o  = single_q ? {wtop[15:8], wtop[15:8]} :
                     cfg_wide ? wtop : {8'h00, wtop[15:8]};

  assert_idle_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ext_rdwr && ext_rd_n && ext_we_n == 2'b11 && !ext_dq_oe));
  assert_narrow_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wide && ext_dq_oe) |-> ext_we_n[1]);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && ext_we_n != 2'b11));
  assert_write_dir_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_we_n != 2'b11) |-> (!ext_rdwr && ext_dq_oe));
endmodule

// File: tb/sram_bus_ctrl_test.sv
module sram_bus_ctrl_test;
  localparam int AW = 24;
  localparam int LW = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wide = 1'b1, cfg_nowait = 1'b0;
  logic [2:0] cfg_iwait = 3'd0;
  logic req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
  logic [1:0] req_size = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_wdata = '0;
  logic req_ready, rsp_done, ext_rd_n, ext_rdwr, ext_dq_oe;
  logic ext_wait = 1'b0;
  logic [LW-1:0] rsp_rdata;
  logic [AW-1:0] ext_addr;
  logic [1:0] ext_we_n;
  logic [15:0] ext_dq_o, ext_dq_i;

  always #5 clk = ~clk;

  sram_bus_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_nowait(cfg_nowait),
    .cfg_iwait(cfg_iwait), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_burst(req_burst),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .ext_addr(ext_addr), .ext_rd_n(ext_rd_n),
    .ext_rdwr(ext_rdwr), .ext_we_n(ext_we_n), .ext_dq_o(ext_dq_o),
    .ext_dq_oe(ext_dq_oe), .ext_dq_i(ext_dq_i), .ext_wait(ext_wait)
  );

  // byte-addressed memory model, 64 bytes
  logic [7:0] mem [64];
  logic [5:0] ma;
  assign ma = ext_addr[5:0];
  always_comb begin
    if (cfg_wide) ext_dq_i = {mem[{ma[5:1], 1'b0}], mem[{ma[5:1], 1'b1}]};
    else          ext_dq_i = {8'h00, mem[ma]};
  end
  always @(posedge clk) begin
    if (cfg_wide) begin
      if (!ext_we_n[1]) mem[{ma[5:1], 1'b0}] <= ext_dq_o[15:8];
      if (!ext_we_n[0]) mem[{ma[5:1], 1'b1}] <= ext_dq_o[7:0];
    end else if (!ext_we_n[0]) begin
      mem[ma] <= ext_dq_o[7:0];
    end
  end

  int n_tests = 0, n_fail = 0;
  logic [LW-1:0] got;
  int act_cyc, n_beats, dir_bad, busy_ready;
  logic [AW-1:0] beat_addr [16];
  logic [1:0] lanes;
  logic done_twice;

  task automatic chk(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] mbytes(input int start, input int n);
    logic [LW-1:0] r = '0;
    for (int i = 0; i < n; i++) r = {r[LW-9:0], mem[(start + i) % 64]};
    return r;
  endfunction

  task automatic init_mem();
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 7 + 3);
  endtask

  task automatic run(input logic wr, input logic [1:0] sz, input logic brst,
                     input logic [AW-1:0] ad, input logic [LW-1:0] wd,
                     input int hold, input logic poke);
    logic [AW-1:0] prev;
    int guard;
    @(negedge clk);
    req_write = wr; req_size = sz; req_burst = brst; req_addr = ad; req_wdata = wd;
    req_valid = 1'b1;
    ext_wait = (hold > 0);
    @(negedge clk);
    req_valid = 1'b0;
    act_cyc = 0; n_beats = 0; dir_bad = 0; busy_ready = 0; lanes = 2'b00;
    prev = '0; guard = 0;
    while (!rsp_done && guard < 500) begin
      if (!ext_rd_n || ext_we_n != 2'b11) begin
        act_cyc++;
        if (n_beats == 0 || ext_addr != prev) begin
          if (n_beats < 16) beat_addr[n_beats] = ext_addr;
          n_beats++;
        end
        prev = ext_addr;
        lanes = lanes | ~ext_we_n;
        if (wr && (ext_rdwr || !ext_dq_oe)) dir_bad++;
        if (!wr && (!ext_rdwr || ext_dq_oe)) dir_bad++;
      end
      if (req_ready) busy_ready++;
      if (act_cyc == hold) ext_wait = 1'b0;
      if (poke && act_cyc == 2) begin
        req_valid = 1'b1; req_write = 1'b1; req_size = 2'd0; req_burst = 1'b0;
        req_addr = 24'h3F; req_wdata = 128'h5A;
      end else begin
        req_valid = 1'b0;
      end
      guard++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    ext_wait = 1'b0;
    if (guard >= 500) chk("R10 done timeout", 0, 1);
    got = rsp_rdata;
    @(negedge clk);
    done_twice = rsp_done;
  endtask

  task automatic t_reset();
    chk("R1 reset idle", {req_ready, ext_rd_n, ext_rdwr, ext_we_n, ext_dq_oe, rsp_done},
        {1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0});
  endtask

  task automatic t_word16();
    cfg_wide = 1; cfg_nowait = 0; cfg_iwait = 0;
    run(0, 2'd2, 0, 24'h04, '0, 0, 0);
    chk("R5 word16 data", got, mbytes(4, 4));
    chk("R5 word16 beats", n_beats, 2);
    chk("R5 word16 addr2", beat_addr[1], 24'h06);
    chk("R7 word16 cycles", act_cyc, 4);
    chk("R10 done single pulse", done_twice, 0);
    chk("R1 idle after", {req_ready, ext_rdwr, ext_rd_n}, 3'b111);
    chk("R11 read dir", dir_bad, 0);
  endtask

  task automatic t_word8();
    cfg_wide = 0;
    run(0, 2'd2, 0, 24'h08, '0, 0, 0);
    chk("R5 word8 data", got, mbytes(8, 4));
    chk("R5 word8 beats", n_beats, 4);
    chk("R5 word8 last addr", beat_addr[3], 24'h0B);
  endtask

  task automatic t_byte16();
    cfg_wide = 1;
    run(0, 2'd0, 0, 24'h05, '0, 0, 0);
    chk("R2 byte16 full width", got, mbytes(4, 2));
    chk("R2 byte16 one beat", n_beats, 1);
    chk("R3 odd start addr", beat_addr[0], 24'h05);
  endtask

  task automatic t_byte8();
    cfg_wide = 0;
    run(0, 2'd0, 0, 24'h05, '0, 0, 0);
    chk("R2 byte8 data", got, mbytes(5, 1));
    chk("R3 byte8 addr", beat_addr[0], 24'h05);
  endtask

  task automatic t_bytewr16();
    logic [7:0] nb;
    cfg_wide = 1;
    nb = mem[6'h20];
    run(1, 2'd0, 0, 24'h21, 128'hA5, 0, 0);
    chk("R4 byte write lane", lanes, 2'b01);
    chk("R4 byte written", mem[6'h21], 8'hA5);
    chk("R4 neighbour kept", mem[6'h20], nb);
    chk("R11 write dir", dir_bad, 0);
  endtask

  task automatic t_halfwr8();
    cfg_wide = 0;
    run(1, 2'd1, 0, 24'h22, 128'hBEEF, 0, 0);
    chk("R4 narrow lane only", lanes, 2'b01);
    chk("R5 half8 beats", n_beats, 2);
    chk("R5 half8 data", {mem[6'h22], mem[6'h23]}, 16'hBEEF);
    chk("R4 half8 neighbour", mem[6'h24], 8'(8'h24 * 7 + 3));
  endtask

  task automatic t_burst16();
    cfg_wide = 1;
    run(0, 2'd0, 1, 24'h13, '0, 0, 0);
    chk("R6 line16 data", got, mbytes(16, 16));
    chk("R6 line16 beats", n_beats, 8);
    chk("R6 line16 base", beat_addr[0], 24'h10);
    chk("R6 line16 no gap", act_cyc, 16);
  endtask

  task automatic t_burst8wr();
    logic [LW-1:0] pat;
    cfg_wide = 0;
    pat = 128'hF0E1D2C3B4A5968778695A4B3C2D1E0F;
    run(1, 2'd2, 1, 24'h37, pat, 0, 0);
    chk("R6 line8 beats", n_beats, 16);
    chk("R6 line8 base", beat_addr[0], 24'h30);
    chk("R6 line8 memory", mbytes(48, 16), pat);
    chk("R6 line8 no gap", act_cyc, 32);
  endtask

  task automatic t_wait();
    cfg_wide = 1; cfg_nowait = 0; cfg_iwait = 0;
    run(0, 2'd0, 0, 24'h02, '0, 5, 0);
    chk("R7 wait stretch cycles", act_cyc, 5);
    chk("R7 wait data", got, mbytes(2, 2));
  endtask

  task automatic t_nowait();
    cfg_nowait = 1;
    run(0, 2'd0, 0, 24'h02, '0, 5, 0);
    chk("R8 wait ignored cycles", act_cyc, 1);
    chk("R8 data", got, mbytes(2, 2));
    cfg_nowait = 0;
  endtask

  task automatic t_iwait();
    cfg_wide = 1; cfg_iwait = 3; cfg_nowait = 0;
    run(0, 2'd2, 0, 24'h08, '0, 0, 0);
    chk("R9 iwait with sample", act_cyc, 10);
    cfg_nowait = 1;
    run(0, 2'd2, 0, 24'h08, '0, 0, 0);
    chk("R9 iwait no sample", act_cyc, 8);
    chk("R9 data", got, mbytes(8, 4));
    cfg_iwait = 0; cfg_nowait = 0;
  endtask

  task automatic t_busy();
    logic [7:0] keep;
    cfg_wide = 0;
    keep = mem[6'h3F];
    run(0, 2'd2, 0, 24'h0C, '0, 0, 1);
    chk("R10 busy request ignored data", got, mbytes(12, 4));
    chk("R10 busy beats", n_beats, 4);
    chk("R10 busy no write", mem[6'h3F], keep);
    chk("R10 ready low while busy", busy_ready, 0);
    repeat (3) @(negedge clk);
    chk("R10 no late start", {req_ready, ext_we_n}, 3'b111);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++; n_tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    init_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word16();
    t_word8();
    t_byte16();
    t_byte8();
    t_bytewr16();
    t_halfwr8();
    t_burst16();
    t_burst8wr();
    t_wait();
    t_nowait();
    t_iwait();
    t_busy();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule